// File: doc/BRIEF.md
# DDR2 Command Spacing Monitor

This block sits beside a DDR2 memory controller and watches the decoded command stream it issues. It checks the spacing between commands against the minimum cycle counts of the memory and raises a separate one-cycle violation flag for each rule that a command breaks. A sticky error flag collects every violation until reset. It drives nothing toward the memory.

Timing values are loaded as picoseconds together with the clock period. After a load pulse, a serial divider turns the precharge time into a whole number of cycles, rounding up. It then adds the programmed write-recovery count to form the window from a write with auto-precharge to the next activate. Checking starts only once the divider reports ready. The fixed windows count clock edges, not elapsed time: two cycles for write-to-read, two cycles for power-down exit to activate, and three registration edges for the CKE level.

Top module: `ddr2_timing_mon`

## Requirements
- R1: After `cfg_load_i` is sampled high, `cfg_ready_o` is low on the next cycle. It later rises with the precharge cycle count equal to ceil(`trp_ps_i` / `tck_ps_i`). For example, 15000/3000 gives 5 and 12501/2500 gives 6.
- R2: An ACTIVATE to bank b fewer than nRP cycles after a PRECHARGE to bank b sets `viol_trp_o`. An ACTIVATE exactly nRP cycles later, or one to a different bank, does not.
- R3: A WRITE with `cmd_ap_i` high to bank b opens a window of WR + nRP cycles. An ACTIVATE to bank b inside that window sets `viol_dal_o`; one at WR + nRP cycles or later does not.
- R4: A READ one cycle after a WRITE sets `viol_wtr_o`. A READ two or more cycles later does not.
- R5: An ACTIVATE one cycle after `pd_exit_i` sets `viol_xp_o`. An ACTIVATE two or more cycles later does not.
- R6: A change in the sampled `cke_i` level one or two edges after a previous registered change sets `viol_cke_o`. A change three or more edges later does not.
- R7: Each violation flag is high for exactly the one cycle that follows the clock edge at which the offending command was sampled.
- R8: `err_sticky_o` goes high together with any violation flag and stays high until reset.
- R9: Reset clears all windows to the satisfied state. After reset, `cfg_ready_o`, `err_sticky_o` and every violation flag are low.
- R10: Commands and CKE changes sampled while `cfg_ready_o` is low raise no violation and open no window. The first command after ready is therefore never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Pulse that latches the configuration and starts conversion |
| tck_ps_i | input | PS_W | Average clock period in ps |
| trp_ps_i | input | PS_W | Precharge time in ps |
| wr_ck_i | input | WR_W | Programmed write recovery in cycles |
| cfg_ready_o | output | 1 | Conversion done, checking active |
| cmd_act_i | input | 1 | ACTIVATE strobe |
| cmd_rd_i | input | 1 | READ strobe |
| cmd_wr_i | input | 1 | WRITE strobe |
| cmd_ap_i | input | 1 | Auto-precharge qualifier for WRITE |
| cmd_pre_i | input | 1 | PRECHARGE strobe |
| bank_i | input | BA_W | Bank address of the command |
| pd_exit_i | input | 1 | Power-down exit strobe |
| cke_i | input | 1 | Clock-enable level |
| viol_trp_o | output | 1 | Precharge-to-activate violation |
| viol_dal_o | output | 1 | Auto-precharge write-to-activate violation |
| viol_wtr_o | output | 1 | Write-to-read violation |
| viol_xp_o | output | 1 | Power-down exit to activate violation |
| viol_cke_o | output | 1 | CKE registration violation |
| err_sticky_o | output | 1 | Sticky OR of all violations |

## Verification
The bench targets each window's boundary cycle, which is the last illegal cycle and then the first legal one. An off-by-one counter load flags the legal edge or lets the illegal one through. It loads a precharge time that is not a multiple of the period. A divider that truncates gives nRP one too small, and the activate at the old boundary then escapes. It sends commands to other banks, so a shared bank window shows up as spurious flags. It issues commands while ready is low and then at the first ready cycle, and a design that arms early flags those. A random phase then mixes all strobes against a cycle-index model.

// File: rtl/ddr2_mon_pkg.sv
package ddr2_mon_pkg;
  localparam int WTR_CK  = 2;
  localparam int XP_CK   = 2;
  localparam int CKE_REG = 3;

  typedef struct packed {
    logic trp;
    logic dal;
    logic wtr;
    logic xp;
    logic cke;
  } viol_t;
endpackage

// File: rtl/ps2clk_div.sv
module ps2clk_div #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         ready_o,
  output logic [W:0]   cyc_o
);
  localparam int SW = (W > 1) ? $clog2(W) : 1;

  logic          busy;
  logic [SW-1:0] step;
  logic [W-1:0]  dvd, dvs, rem, quo;
  logic [W:0]    rem_sh, rem_nx;
  logic          ge;
  logic [W-1:0]  quo_nx;

  always_comb begin
    rem_sh = {rem, dvd[W-1]};
    ge     = rem_sh >= {1'b0, dvs};
    rem_nx = ge ? (rem_sh - {1'b0, dvs}) : rem_sh;
    quo_nx = {quo[W-2:0], ge};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy    <= 1'b0;
      step    <= '0;
      dvd     <= '0;
      dvs     <= '0;
      rem     <= '0;
      quo     <= '0;
      ready_o <= 1'b0;
      cyc_o   <= '0;
    end else if (start_i) begin
      busy    <= 1'b1;
      step    <= '0;
      dvd     <= dvd_i;
      dvs     <= dvs_i;
      rem     <= '0;
      quo     <= '0;
      ready_o <= 1'b0;
    end else if (busy) begin
      dvd  <= {dvd[W-2:0], 1'b0};
      rem  <= rem_nx[W-1:0];
      quo  <= quo_nx;
      step <= step + 1'b1;
      if (step == SW'(W-1)) begin
        busy    <= 1'b0;
        ready_o <= 1'b1;
        // round up on any remainder
        cyc_o   <= {1'b0, quo_nx} + (W+1)'(rem_nx != '0);
      end
    end
  end
endmodule

// File: rtl/win_cnt.sv
module win_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         busy_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt <= '0;
    else if (clr_i)             cnt <= '0;
    else if (en_i) begin
      if (load_i)               cnt <= (len_i == '0) ? '0 : len_i - 1'b1;
      else if (cnt != '0)       cnt <= cnt - 1'b1;
    end
  end

  assign busy_o = cnt != '0;
endmodule

// File: rtl/ddr2_timing_mon.sv
module ddr2_timing_mon
  import ddr2_mon_pkg::*;
#(
  parameter int PS_W  = 16,
  parameter int BANKS = 8,
  parameter int WR_W  = 4,
  localparam int BA_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_load_i,
  input  logic [PS_W-1:0] tck_ps_i,
  input  logic [PS_W-1:0] trp_ps_i,
  input  logic [WR_W-1:0] wr_ck_i,
  output logic            cfg_ready_o,
  input  logic            cmd_act_i,
  input  logic            cmd_rd_i,
  input  logic            cmd_wr_i,
  input  logic            cmd_ap_i,
  input  logic            cmd_pre_i,
  input  logic [BA_W-1:0] bank_i,
  input  logic            pd_exit_i,
  input  logic            cke_i,
  output logic            viol_trp_o,
  output logic            viol_dal_o,
  output logic            viol_wtr_o,
  output logic            viol_xp_o,
  output logic            viol_cke_o,
  output logic            err_sticky_o
);
  localparam int CNT_W = PS_W + 2;

  logic [PS_W:0]    nrp;
  logic [WR_W-1:0]  wr_q;
  logic [CNT_W-1:0] rp_len, dal_len;
  logic             armed;
  logic [BANKS-1:0] rp_busy, dal_busy;
  logic             wtr_busy, xp_busy, cke_busy;
  logic             cke_q, cke_chg;
  viol_t            v_d, v_q;

  ps2clk_div #(.W(PS_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cfg_load_i),
    .dvd_i   (trp_ps_i),
    .dvs_i   (tck_ps_i),
    .ready_o (cfg_ready_o),
    .cyc_o   (nrp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wr_q <= '0;
    else if (cfg_load_i) wr_q <= wr_ck_i;
  end

  assign armed   = cfg_ready_o;
  assign rp_len  = CNT_W'(nrp);
  assign dal_len = CNT_W'(nrp) + CNT_W'(wr_q);

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic hit;
    assign hit = bank_i == BA_W'(g);

    win_cnt #(.W(CNT_W)) u_rp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!armed),
      .en_i   (armed),
      .load_i (cmd_pre_i && hit),
      .len_i  (rp_len),
      .busy_o (rp_busy[g])
    );

    win_cnt #(.W(CNT_W)) u_dal (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!armed),
      .en_i   (armed),
      .load_i (cmd_wr_i && cmd_ap_i && hit),
      .len_i  (dal_len),
      .busy_o (dal_busy[g])
    );
  end

  win_cnt #(.W(CNT_W)) u_wtr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!armed),
    .en_i   (armed),
    .load_i (cmd_wr_i),
    .len_i  (CNT_W'(WTR_CK)),
    .busy_o (wtr_busy)
  );

  win_cnt #(.W(CNT_W)) u_xp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!armed),
    .en_i   (armed),
    .load_i (pd_exit_i),
    .len_i  (CNT_W'(XP_CK)),
    .busy_o (xp_busy)
  );

  // CKE level is tracked even when unarmed so the first armed edge sees no false change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b0;
    else         cke_q <= cke_i;
  end
  assign cke_chg = cke_i != cke_q;

  win_cnt #(.W(CNT_W)) u_cke (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!armed),
    .en_i   (armed),
    .load_i (cke_chg),
    .len_i  (CNT_W'(CKE_REG)),
    .busy_o (cke_busy)
  );

  always_comb begin
    v_d.trp = armed && cmd_act_i && rp_busy[bank_i];
    v_d.dal = armed && cmd_act_i && dal_busy[bank_i];
    v_d.wtr = armed && cmd_rd_i && wtr_busy;
    v_d.xp  = armed && cmd_act_i && xp_busy;
    v_d.cke = armed && cke_chg && cke_busy;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q          <= '0;
      err_sticky_o <= 1'b0;
    end else begin
      v_q          <= v_d;
      err_sticky_o <= err_sticky_o || (v_d != '0);
    end
  end

  assign viol_trp_o = v_q.trp;
  assign viol_dal_o = v_q.dal;
  assign viol_wtr_o = v_q.wtr;
  assign viol_xp_o  = v_q.xp;
  assign viol_cke_o = v_q.cke;
endmodule

// File: rtl/ddr2_timing_mon_chk.sv
module ddr2_timing_mon_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_load_i,
  input logic cfg_ready_o,
  input logic cmd_act_i,
  input logic cmd_rd_i,
  input logic cmd_wr_i,
  input logic viol_trp_o,
  input logic viol_dal_o,
  input logic viol_wtr_o,
  input logic viol_xp_o,
  input logic viol_cke_o,
  input logic err_sticky_o
);
  logic any_v;
  assign any_v = viol_trp_o || viol_dal_o || viol_wtr_o || viol_xp_o || viol_cke_o;

  // R1
  load_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> !cfg_ready_o);

  // R10
  no_viol_unarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!cfg_ready_o) |-> !any_v);

  // R2
  trp_after_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_trp_o || viol_dal_o) |-> $past(cmd_act_i));

  // R5
  xp_after_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_xp_o |-> $past(cmd_act_i));

  // R4
  wtr_tight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ready_o && !cfg_load_i && cmd_wr_i) ##1 cmd_rd_i |=> viol_wtr_o);

  // R8
  err_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_v |-> err_sticky_o);

  // R8
  err_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_sticky_o |=> err_sticky_o);
endmodule

bind ddr2_timing_mon ddr2_timing_mon_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_load_i   (cfg_load_i),
  .cfg_ready_o  (cfg_ready_o),
  .cmd_act_i    (cmd_act_i),
  .cmd_rd_i     (cmd_rd_i),
  .cmd_wr_i     (cmd_wr_i),
  .viol_trp_o   (viol_trp_o),
  .viol_dal_o   (viol_dal_o),
  .viol_wtr_o   (viol_wtr_o),
  .viol_xp_o    (viol_xp_o),
  .viol_cke_o   (viol_cke_o),
  .err_sticky_o (err_sticky_o)
);

// File: tb/sim_ddr2_timing_mon.sv
`timescale 1ns/1ps
module sim_ddr2_timing_mon;
  logic        clk_i = 0, rst_ni = 0;
  logic        cfg_load_i = 0;
  logic [15:0] tck_ps_i = 0, trp_ps_i = 0;
  logic [3:0]  wr_ck_i = 0;
  logic        cfg_ready_o;
  logic        cmd_act_i = 0, cmd_rd_i = 0, cmd_wr_i = 0, cmd_ap_i = 0, cmd_pre_i = 0;
  logic [2:0]  bank_i = 0;
  logic        pd_exit_i = 0, cke_i = 1;
  logic        viol_trp_o, viol_dal_o, viol_wtr_o, viol_xp_o, viol_cke_o, err_sticky_o;

  ddr2_timing_mon u0 (.*);

  always #2.5 clk_i = ~clk_i;

  int compared = 0, mismatched = 0;
  int cyc = 0;
  int nrp_m = 0, ndal_m = 0;
  int pre_c[8], dal_c[8];
  int wr_c, xp_c, cke_c;
  bit cke_prev = 1, armed_m = 0, err_m = 0;
  bit pend = 0;
  bit e_trp, e_dal, e_wtr, e_xp, e_cke;
  string pend_tag;

  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0b expected %0b at step %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) begin pre_c[i] = -1000; dal_c[i] = -1000; end
    wr_c = -1000; xp_c = -1000; cke_c = -1000;
  endtask

  task automatic check_pend();
    if (pend) begin
      chk({pend_tag, " R2 trp"}, viol_trp_o, e_trp);
      chk({pend_tag, " R3 dal"}, viol_dal_o, e_dal);
      chk({pend_tag, " R4 wtr"}, viol_wtr_o, e_wtr);
      chk({pend_tag, " R5 xp"},  viol_xp_o,  e_xp);
      chk({pend_tag, " R6 cke"}, viol_cke_o, e_cke);
      chk({pend_tag, " R8 err"}, err_sticky_o, err_m);
      pend = 0;
    end
  endtask

  // drive one command cycle; its effect is checked one cycle later (R7)
  task automatic step(string tag, bit act, bit rd, bit wr, bit ap, bit pre,
                      int b, bit xpx, bit cke);
    bit chg;
    @(negedge clk_i);
    check_pend();
    armed_m = cfg_ready_o;
    cmd_act_i = act; cmd_rd_i = rd; cmd_wr_i = wr; cmd_ap_i = ap; cmd_pre_i = pre;
    bank_i = 3'(b); pd_exit_i = xpx; cke_i = cke;
    chg = cke != cke_prev;
    cke_prev = cke;
    e_trp = 0; e_dal = 0; e_wtr = 0; e_xp = 0; e_cke = 0;
    if (armed_m) begin
      e_trp = act && (cyc - pre_c[b] < nrp_m);
      e_dal = act && (cyc - dal_c[b] < ndal_m);
      e_wtr = rd && (cyc - wr_c < 2);
      e_xp  = act && (cyc - xp_c < 2);
      e_cke = chg && (cyc - cke_c < 3);
      if (pre) pre_c[b] = cyc;
      if (wr && ap) dal_c[b] = cyc;
      if (wr) wr_c = cyc;
      if (xpx) xp_c = cyc;
      if (chg) cke_c = cyc;
    end
    err_m = err_m | e_trp | e_dal | e_wtr | e_xp | e_cke;
    pend_tag = tag;
    pend = 1;
    cyc++;
  endtask

  task automatic idle(int n, bit cke = 1);
    for (int i = 0; i < n; i++) step("idle", 0, 0, 0, 0, 0, 0, 0, cke);
  endtask

  task automatic load_cfg(int tck, int trp, int wr, bit early_cmds);
    @(negedge clk_i);
    check_pend();
    cmd_act_i = 0; cmd_rd_i = 0; cmd_wr_i = 0; cmd_pre_i = 0; pd_exit_i = 0;
    cfg_load_i = 1; tck_ps_i = 16'(tck); trp_ps_i = 16'(trp); wr_ck_i = 4'(wr);
    @(negedge clk_i);
    cfg_load_i = 0;
    chk("R1 ready low after load", cfg_ready_o, 1'b0);
    model_clear();
    nrp_m = ceil_div(trp, tck);
    ndal_m = wr + nrp_m;
    // R10: commands while unarmed must not flag nor open windows
    if (early_cmds) begin
      step("R10 pre unarmed", 0, 0, 0, 0, 1, 0, 0, 1);
      step("R10 wr unarmed",  0, 0, 1, 1, 0, 0, 0, 1);
      step("R10 act unarmed", 1, 1, 0, 0, 0, 0, 0, 1);
    end
    for (int i = 0; i < 40 && !cfg_ready_o; i++) idle(1);
    chk("R1 ready rises", cfg_ready_o, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    model_clear();
    #12 rst_ni = 1;
    @(negedge clk_i);
    // R9 reset state
    chk("R9 ready", cfg_ready_o, 1'b0);
    chk("R9 err", err_sticky_o, 1'b0);
    chk("R9 viol", viol_trp_o | viol_dal_o | viol_wtr_o | viol_xp_o | viol_cke_o, 1'b0);

    // config A: 3000 ps, 15000 ps -> nRP 5, WR 5 -> DAL 10
    load_cfg(3000, 15000, 5, 1);
    // R10: first command after ready clean
    step("R10 first act", 1, 0, 0, 0, 0, 0, 0, 1);
    idle(2);
    // R2 boundary: ACT at +4 illegal, +5 legal
    step("R2 pre b1", 0, 0, 0, 0, 1, 1, 0, 1);
    idle(3);
    step("R2 act b1 at 4", 1, 0, 0, 0, 0, 1, 0, 1);
    step("R2 act b1 at 5", 1, 0, 0, 0, 0, 1, 0, 1);
    // R2 other bank unaffected
    step("R2 pre b2", 0, 0, 0, 0, 1, 2, 0, 1);
    step("R2 act b3", 1, 0, 0, 0, 0, 3, 0, 1);
    idle(6);
    // R3 DAL: ACT at +9 illegal, +10 legal
    step("R3 wr ap b4", 0, 0, 1, 1, 0, 4, 0, 1);
    idle(8);
    step("R3 act b4 at 9", 1, 0, 0, 0, 0, 4, 0, 1);
    step("R3 act b4 at 10", 1, 0, 0, 0, 0, 4, 0, 1);
    // R4 WTR
    step("R4 wr", 0, 0, 1, 0, 0, 0, 0, 1);
    step("R4 rd at 1", 0, 1, 0, 0, 0, 0, 0, 1);
    step("R4 wr", 0, 0, 1, 0, 0, 0, 0, 1);
    idle(1);
    step("R4 rd at 2", 0, 1, 0, 0, 0, 0, 0, 1);
    // R5 XP
    step("R5 exit", 0, 0, 0, 0, 0, 5, 1, 1);
    step("R5 act at 1", 1, 0, 0, 0, 0, 5, 0, 1);
    step("R5 exit", 0, 0, 0, 0, 0, 5, 1, 1);
    idle(1);
    step("R5 act at 2", 1, 0, 0, 0, 0, 5, 0, 1);
    // R6 CKE: change, change at +2 illegal, then +3 legal
    step("R6 cke low", 0, 0, 0, 0, 0, 0, 0, 0);
    idle(1, 0);
    step("R6 cke high at 2", 0, 0, 0, 0, 0, 0, 0, 1);
    idle(2, 1);
    step("R6 cke low at 3", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6 cke high at 1", 0, 0, 0, 0, 0, 0, 0, 1);
    idle(4);

    // config B: 2500 ps, 12501 ps -> nRP 6 (round up), WR 3
    load_cfg(2500, 12501, 3, 0);
    step("R1 pre b0", 0, 0, 0, 0, 1, 0, 0, 1);
    idle(4);
    step("R1 act at 5 (nRP 6)", 1, 0, 0, 0, 0, 0, 0, 1);
    step("R1 act at 6", 1, 0, 0, 0, 0, 0, 0, 1);

    // random mix, fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      bit a, r, w, ap, p, x, k;
      int b;
      a  = ($urandom % 5) == 0;
      r  = ($urandom % 5) == 0;
      w  = ($urandom % 6) == 0;
      ap = ($urandom % 2) == 0;
      p  = ($urandom % 5) == 0;
      x  = ($urandom % 8) == 0;
      b  = int'($urandom % 3);
      k  = (($urandom % 6) == 0) ? !cke_prev : cke_prev;
      step("rand", a, r, w, ap, p, b, x, k);
    end
    idle(2);
    @(negedge clk_i);
    check_pend();

    // R8 err still held, then R9 reset clears it
    chk("R8 err held", err_sticky_o, err_m);
    rst_ni = 0;
    #1;
    chk("R9 err cleared", err_sticky_o, 1'b0);
    chk("R9 ready cleared", cfg_ready_o, 1'b0);
    rst_ni = 1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule